// File: doc/BRIEF.md
# Pulse-Pause Reader Frame Transmitter

This block sends one reader-to-tag frame by switching a carrier-enable output. The value of each bit sits in its total length. A bit opens with a fixed stretch of carrier off, then the carrier comes back on, and the bit ends after a long time for a one or a short time for a zero. All timing counts in ticks, and one tick is a fixed number of system clocks (32 by default). Before a data bit is sent it is XORed with the current bit of an external keystream. The block steps that keystream once per bit, on the first clock of the carrier-on part.

A frame holds up to 32 bits and is sent least significant bit first. A one-cycle start strobe launches it, with a data word and a bit count. The last bit is followed by one more carrier-off pause. The carrier then comes back on, and a one-cycle done pulse restarts the shared timer that measures the wait for the tag's reply. While a frame is in flight the block ignores any start request. The carrier stays on while the block is idle.

Top module: `pp_reader_tx`

## Requirements
- R1: Out of reset and whenever idle, `carrier_on` is 1 and `busy`, `ks_adv` and `frame_done` are 0.
- R2: Each bit begins with `carrier_on` low for exactly PAUSE_T ticks (PAUSE_T*DIV clocks), starting in the cycle after the accepting start edge or after the previous bit ends.
- R3: The whole bit, pause included, lasts ONE_T ticks when the sent value is 1 and ZERO_T ticks when it is 0, with `carrier_on` high after the pause.
- R4: Data bits go out in order from bit 0 (least significant) upward.
- R5: The sent value of each bit is `tx_data[i] ^ ks_bit`, with `ks_bit` sampled on the clock edge that ends that bit's pause.
- R6: `ks_adv` is a one-cycle pulse, exactly one per sent bit, in the first cycle of the bit's carrier-on part.
- R7: After the last bit, `carrier_on` is low for PAUSE_T ticks more and then returns high.
- R8: `frame_done` pulses for one cycle in the first cycle that the carrier is back on after the closing pause. `busy` is low in that same cycle and high from the accepting edge until then.
- R9: A `start` seen while `busy` is 1, or in the cycle the closing pause ends, has no effect on the frame in flight and launches no frame.
- R10: A bit count of 0 sends only the closing pause. Counts above MAXB are treated as MAXB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame launch request, accepted only when idle |
| tx_data | input | MAXB (32) | Frame payload, bit 0 sent first |
| tx_bits | input | NBW (7) | Number of bits to send, clamped to MAXB |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Keystream step request, one per bit |
| carrier_on | output | 1 | Carrier enable, low during pauses |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse for the response timer |

## Verification
The hardest case to reach is the boundary between frames. A start that arrives at the same edge where the closing pause ends must be dropped, and a start on the next edge must be taken at once. The bench holds `start` high for a full frame and through its end, so the block meets a request on every edge, including the edge of the last pause. Keystream alignment is exercised by a bench keystream that steps only on the block's own `ks_adv`. A missing or extra step therefore shifts every later bit length against the reference.

// File: rtl/pp_tx_pkg.sv
package pp_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_ON    = 2'd2,
    ST_CLOSE = 2'd3
  } tx_state_e;
endpackage

// File: rtl/pp_tick_div.sv
module pp_tick_div #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pp_seg_timer.sv
module pp_seg_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [TW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/pp_bit_shifter.sv
module pp_bit_shifter #(
  parameter int MAXB = 32,
  parameter int NBW  = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic [MAXB-1:0] data_in,
  input  logic [NBW-1:0]  count_in,
  output logic            cur_bit,
  output logic            last_bit
);
  logic [MAXB-1:0] sreg;
  logic [NBW-1:0]  left;

  assign cur_bit  = sreg[0];
  assign last_bit = (left == NBW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= data_in;
      left <= count_in;
    end else if (shift) begin
      sreg <= {1'b0, sreg[MAXB-1:1]};
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/pp_reader_tx.sv
module pp_reader_tx
  import pp_tx_pkg::*;
#(
  parameter int DIV     = 32,
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 150,
  parameter int ZERO_T  = 90,
  parameter int MAXB    = 32,
  parameter int NBW     = $clog2(MAXB + 1) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [MAXB-1:0] tx_data,
  input  logic [NBW-1:0]  tx_bits,
  input  logic            ks_bit,
  output logic            ks_adv,
  output logic            carrier_on,
  output logic            busy,
  output logic            frame_done
);
  localparam int LONGEST = (ONE_T > ZERO_T) ? ONE_T : ZERO_T;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam logic [TW-1:0]  PAUSE_LAST = TW'(PAUSE_T - 1);
  localparam logic [TW-1:0]  ONE_LAST   = TW'(ONE_T - 1);
  localparam logic [TW-1:0]  ZERO_LAST  = TW'(ZERO_T - 1);
  localparam logic [NBW-1:0] MAXB_N     = NBW'(MAXB);

  tx_state_e       state;
  logic [TW-1:0]   tcnt;
  logic [TW-1:0]   bit_last_q;
  logic            tick;
  logic            accept;
  logic            pause_end;
  logic            bit_end;
  logic            seg_clr;
  logic            shift;
  logic            cur_bit;
  logic            last_bit;
  logic            sent_bit;
  logic [NBW-1:0]  bits_clamped;

  assign busy         = (state != ST_IDLE);
  assign accept       = start && (state == ST_IDLE);
  assign bits_clamped = (tx_bits > MAXB_N) ? MAXB_N : tx_bits;
  assign pause_end    = tick && (tcnt == PAUSE_LAST);
  assign bit_end      = tick && (tcnt == bit_last_q);
  assign shift        = (state == ST_ON) && bit_end;
  assign seg_clr      = accept || shift;
  assign sent_bit     = cur_bit ^ ks_bit;

  pp_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .en   (busy),
    .tick (tick)
  );

  pp_seg_timer #(.TW(TW)) u_seg (
    .clk   (clk),
    .rst   (rst),
    .clr   (seg_clr),
    .tick  (tick),
    .count (tcnt)
  );

  pp_bit_shifter #(.MAXB(MAXB), .NBW(NBW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .shift    (shift),
    .data_in  (tx_data),
    .count_in (bits_clamped),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      carrier_on <= 1'b1;
      ks_adv     <= 1'b0;
      frame_done <= 1'b0;
      bit_last_q <= ZERO_LAST;
    end else begin
      ks_adv     <= 1'b0;
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            carrier_on <= 1'b0;
            state      <= (bits_clamped == '0) ? ST_CLOSE : ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          if (pause_end) begin
            carrier_on <= 1'b1;
            ks_adv     <= 1'b1;
            bit_last_q <= sent_bit ? ONE_LAST : ZERO_LAST;
            state      <= ST_ON;
          end
        end
        ST_ON: begin
          if (bit_end) begin
            carrier_on <= 1'b0;
            state      <= last_bit ? ST_CLOSE : ST_PAUSE;
          end
        end
        ST_CLOSE: begin
          if (pause_end) begin
            carrier_on <= 1'b1;
            frame_done <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_reader_tx_chk.sv
module pp_reader_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ks_adv,
  input logic carrier_on,
  input logic busy,
  input logic frame_done
);
  assert_idle_carrier_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> carrier_on);

  assert_adv_single_R6: assert property (@(posedge clk) disable iff (rst)
    ks_adv |=> !ks_adv);

  assert_adv_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    ks_adv |-> ($rose(carrier_on) && busy));

  assert_close_low_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !$past(carrier_on));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (carrier_on && !busy && $past(busy)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind pp_reader_tx pp_reader_tx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .ks_adv     (ks_adv),
  .carrier_on (carrier_on),
  .busy       (busy),
  .frame_done (frame_done)
);

// File: tb/sim_pp_reader_tx.sv
`timescale 1ns/1ps
module sim_pp_reader_tx;
  localparam int DIV     = 2;
  localparam int PAUSE_T = 3;
  localparam int ONE_T   = 7;
  localparam int ZERO_T  = 5;
  localparam int MAXB    = 32;
  localparam int NBW     = $clog2(MAXB + 1) + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [MAXB-1:0] tx_data = '0;
  logic [NBW-1:0]  tx_bits = '0;
  logic            ks_bit;
  logic            ks_adv;
  logic            carrier_on;
  logic            busy;
  logic            frame_done;

  always #5 clk = ~clk;

  pp_reader_tx #(
    .DIV(DIV), .PAUSE_T(PAUSE_T), .ONE_T(ONE_T), .ZERO_T(ZERO_T), .MAXB(MAXB)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .tx_data(tx_data), .tx_bits(tx_bits),
    .ks_bit(ks_bit), .ks_adv(ks_adv), .carrier_on(carrier_on), .busy(busy),
    .frame_done(frame_done)
  );

  // keystream source stepped only by the block's own requests
  logic       ks_arr [256];
  logic [7:0] ks_idx = '0;
  assign ks_bit = ks_arr[ks_idx];
  always @(posedge clk) if (!rst && ks_adv) ks_idx <= ks_idx + 8'd1;

  int checks = 0;
  int errors = 0;
  int model_ks = 0;
  int model_frames = 0;
  int dut_frames = 0;
  int cycles = 0;
  string note = "R4 R5";

  // entry: [0]=carrier [1]=adv [2]=done [3]=busy, tag in upper bits
  int q[$];
  logic            cap_start = 1'b0;
  logic [MAXB-1:0] cap_data = '0;
  logic [NBW-1:0]  cap_bits = '0;

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void push_n(int n, int val, int tag);
    for (int k = 0; k < n; k++) q.push_back(val | (tag << 4));
  endfunction

  function automatic void build(logic [MAXB-1:0] d, int nb);
    int nbc = (nb > MAXB) ? MAXB : nb;
    int tagc = (nb == 0 || nb > MAXB) ? 10 : 7;
    for (int i = 0; i < nbc; i++) begin
      bit b = d[i] ^ ks_arr[(model_ks + i) % 256];
      int len = b ? ONE_T : ZERO_T;
      push_n(PAUSE_T * DIV, 4'b1000, 2);
      q.push_back(4'b1011 | (6 << 4));
      push_n((len - PAUSE_T) * DIV - 1, 4'b1001, 3);
    end
    model_ks += nbc;
    model_frames++;
    push_n(PAUSE_T * DIV, 4'b1000, tagc);
    q.push_back(4'b0101 | (8 << 4));
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      cap_start <= 1'b0;
    end else begin
      int e;
      int act;
      cycles++;
      if (cap_start && q.size() == 0) build(cap_data, int'(cap_bits));
      e = (q.size() > 0) ? q.pop_front() : (4'b0001 | (1 << 4));
      act = {busy, frame_done, ks_adv, carrier_on};
      check(act == (e & 15), {tag_name(e >> 4), " ", note}, act, e & 15);
      if (frame_done) dut_frames++;
      cap_start = start;
      cap_data  = tx_data;
      cap_bits  = tx_bits;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!frame_done);
  endtask

  task automatic send(logic [MAXB-1:0] d, int nb, string n);
    @(posedge clk); #1;
    note = n; tx_data = d; tx_bits = NBW'(nb); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int lfsr = 16'hACE1;
    for (int i = 0; i < 256; i++) begin
      ks_arr[i] = lfsr[0];
      lfsr = {16'(0), lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(carrier_on && !busy && !ks_adv && !frame_done, "R1 reset",
          {busy, frame_done, ks_adv, carrier_on}, 4'b0001);

    send(32'h0000_00A5, 8, "R4 R5 byte");
    send(32'h0000_0000, 12, "R5 zero data");
    send(32'hFFFF_FFFF, 16, "R3 R5 ones");
    send(32'h1234_5678, 32, "R4 full word");
    send(32'h0000_0001, 1, "R4 single bit");
    send(32'h0000_0055, 0, "R10 empty");
    send(32'h9ABC_DEF0, 40, "R10 clamp");

    // start requests while a frame runs must be dropped
    @(posedge clk); #1;
    note = "R9 mid-frame"; tx_data = 32'h0000_0F0F; tx_bits = NBW'(10); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    repeat (20) @(posedge clk);
    #1 tx_data = 32'hFFFF_0000; tx_bits = NBW'(3); start = 1'b1;
    repeat (3) @(posedge clk);
    #1 start = 1'b0; tx_data = 32'h0000_0F0F; tx_bits = NBW'(10);
    wait_done();
    repeat (3) @(posedge clk);

    // start held through the end of a frame: taken again on the first idle edge
    @(posedge clk); #1;
    note = "R9 held start"; tx_data = 32'h0000_0036; tx_bits = NBW'(6); start = 1'b1;
    wait_done();
    @(posedge clk); #1 start = 1'b0;
    wait_done();
    repeat (4) @(posedge clk);
    @(negedge clk);

    check(dut_frames == model_frames, "R9 frame count", dut_frames, model_frames);
    check(int'(ks_idx) == (model_ks % 256), "R6 keystream steps", ks_idx, model_ks % 256);
    check(q.size() == 0, "R8 frame closed", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule